// File: doc/BRIEF.md
# AXI Channel Dual-Clock Handshake FIFO

This block moves the packed payload of a single AXI channel from one clock domain into another, unrelated one. On each side it looks like an ordinary VALID/READY port. The source domain sees a READY that drops only when the queue has no room. The destination domain sees a VALID that stays high for as long as a beat is waiting. Beats are kept in a small dual-clock memory. Only the write and read pointers cross the boundary. They cross as Gray codes through flop synchronizers, and the payload bits themselves are never synchronized.

A bridge for a complete AXI interface uses one instance per channel. The three request channels are written in the manager clock. The two response channels are written in the subordinate clock. Each domain has its own asynchronous active-low reset. The full and empty flags are registered and conservative. They may clear a few cycles after room or data appears, but they never report room or data that is not there.

Top module: `axiChanCdcFifo`

## Requirements
- R1: On a source-clock edge, a beat is stored exactly when srcValid and srcReady are both high. srcReady is high exactly when the queue is not full.
- R2: After reset, srcReady is high and dstValid is low. dstValid is never high while no unread beat is present.
- R3: While the destination never accepts, the source can place exactly 2^ADDR_W beats. srcReady is then low and stays low while srcValid is held.
- R4: Beats arrive at the destination in the order they were accepted, with none lost, duplicated or corrupted. Every Gray-coded pointer changes by at most one bit per edge of its own clock.
- R5: While dstValid is high and dstReady is low, dstValid stays high and dstData keeps its value on the next destination edge.
- R6: srcReady falls only on the edge right after an accepted source beat. dstValid falls only on the edge right after an accepted destination beat.
- R7: Once a beat is removed from a full queue, srcReady returns high within 8 source-clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcClk | input | 1 | Source-domain clock |
| srcRstN | input | 1 | Source-domain asynchronous reset, active low |
| srcValid | input | 1 | Source offers a beat |
| srcReady | output | 1 | Queue has room (not full) |
| srcData | input | DATA_W | Packed channel payload from the source |
| dstClk | input | 1 | Destination-domain clock |
| dstRstN | input | 1 | Destination-domain asynchronous reset, active low |
| dstValid | output | 1 | A beat is waiting (not empty) |
| dstReady | input | 1 | Destination accepts the offered beat |
| dstData | output | DATA_W | Oldest unread payload |

## Verification
The bench builds the block with ADDR_W=2, which gives four entries, and with DATA_W=32. A shallow queue fills after a few beats, so the full flag, the backpressure hold, the recovery from full and many pointer wrap-arounds all occur within a short run. Every wrap also passes through the transitions of the most significant pointer bits that the full comparison depends on. The source clock runs at 125 MHz and the destination clock at an unrelated, slower rate. This makes the synchronized pointers slide against each other in phase while random stalls are applied on both sides.

// File: rtl/axiChanCdcPkg.sv
package axiChanCdcPkg;
  // Strobes passed from the pointer control to the storage datapath.
  typedef struct packed {
    logic wrEn;
  } fifoStrobes_t;
endpackage

// File: rtl/axiChanPtrSync.sv
module axiChanPtrSync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[s] <= '0;
        else if (s == 0) stageQ[s] <= asyncIn;
        else stageQ[s] <= stageQ[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/axiChanCdcCtrl.sv
module axiChanCdcCtrl
  import axiChanCdcPkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int SYNC_STAGES = 2,
  localparam int PTR_W = ADDR_W + 1
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic              wrValid,
  output logic              wrReady,
  output logic [ADDR_W-1:0] wrAddr,
  input  logic              rdClk,
  input  logic              rdRstN,
  output logic              rdValid,
  input  logic              rdReady,
  output logic [ADDR_W-1:0] rdAddr,
  output fifoStrobes_t      strobes
);
  logic [PTR_W-1:0] wrBin, wrBinNext, wrGray, wrGrayNext, rdGrayInWr;
  logic [PTR_W-1:0] rdBin, rdBinNext, rdGray, rdGrayNext, wrGrayInRd;
  logic             fullQ, emptyQ, wrEn, rdEn;

  // ---------------- write domain ----------------
  assign wrReady    = !fullQ;
  assign wrEn       = wrValid && !fullQ;
  assign wrBinNext  = wrBin + PTR_W'(wrEn);
  assign wrGrayNext = (wrBinNext >> 1) ^ wrBinNext;
  assign wrAddr     = wrBin[ADDR_W-1:0];
  assign strobes.wrEn = wrEn;

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      wrBin  <= '0;
      wrGray <= '0;
      fullQ  <= 1'b0;
    end else begin
      wrBin  <= wrBinNext;
      wrGray <= wrGrayNext;
      fullQ  <= (wrGrayNext == {~rdGrayInWr[PTR_W-1:PTR_W-2], rdGrayInWr[PTR_W-3:0]});
    end
  end

  axiChanPtrSync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_rdToWr (
    .clk(wrClk), .rstN(wrRstN), .asyncIn(rdGray), .syncOut(rdGrayInWr)
  );

  // ---------------- read domain ----------------
  assign rdValid    = !emptyQ;
  assign rdEn       = rdReady && !emptyQ;
  assign rdBinNext  = rdBin + PTR_W'(rdEn);
  assign rdGrayNext = (rdBinNext >> 1) ^ rdBinNext;
  assign rdAddr     = rdBin[ADDR_W-1:0];

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rdBin  <= '0;
      rdGray <= '0;
      emptyQ <= 1'b1;
    end else begin
      rdBin  <= rdBinNext;
      rdGray <= rdGrayNext;
      emptyQ <= (rdGrayNext == wrGrayInRd);
    end
  end

  axiChanPtrSync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_wrToRd (
    .clk(rdClk), .rstN(rdRstN), .asyncIn(wrGray), .syncOut(wrGrayInRd)
  );

  // ---------------- assertions ----------------
  assert_src_ready_fall_R6: assert property (@(posedge wrClk) disable iff (!wrRstN)
    $fell(wrReady) |-> $past(wrValid && wrReady));
  assert_dst_valid_fall_R6: assert property (@(posedge rdClk) disable iff (!rdRstN)
    $fell(rdValid) |-> $past(rdValid && rdReady));
  assert_wr_gray_step_R4: assert property (@(posedge wrClk) disable iff (!wrRstN)
    $countones(wrGray ^ $past(wrGray)) <= 1);
  assert_rd_gray_step_R4: assert property (@(posedge rdClk) disable iff (!rdRstN)
    $countones(rdGray ^ $past(rdGray)) <= 1);
endmodule

// File: rtl/axiChanCdcStore.sv
module axiChanCdcStore
  import axiChanCdcPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              wrClk,
  input  fifoStrobes_t      strobes,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strobes.wrEn) mem[wrAddr] <= wrData;
  end

  // Read is only consumed once the control reports the entry present.
  assign rdData = mem[rdAddr];
endmodule

// File: rtl/axiChanCdcFifo.sv
module axiChanCdcFifo
  import axiChanCdcPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              srcClk,
  input  logic              srcRstN,
  input  logic              srcValid,
  output logic              srcReady,
  input  logic [DATA_W-1:0] srcData,
  input  logic              dstClk,
  input  logic              dstRstN,
  output logic              dstValid,
  input  logic              dstReady,
  output logic [DATA_W-1:0] dstData
);
  fifoStrobes_t      strobes;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  axiChanCdcCtrl #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .wrClk(srcClk), .wrRstN(srcRstN), .wrValid(srcValid), .wrReady(srcReady),
    .wrAddr(wrAddr), .rdClk(dstClk), .rdRstN(dstRstN), .rdValid(dstValid),
    .rdReady(dstReady), .rdAddr(rdAddr), .strobes(strobes)
  );

  axiChanCdcStore #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .wrClk(srcClk), .strobes(strobes), .wrAddr(wrAddr), .wrData(srcData),
    .rdAddr(rdAddr), .rdData(dstData)
  );

  assert_dst_hold_R5: assert property (@(posedge dstClk) disable iff (!dstRstN)
    (dstValid && !dstReady) |=> (dstValid && $stable(dstData)));
endmodule

// File: tb/axiChanCdcFifo_tb.sv
`timescale 1ns/100ps
module axiChanCdcFifo_tb;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;
  localparam int DEPTH  = 1 << ADDR_W;

  logic srcClk = 0, dstClk = 0, srcRstN = 0, dstRstN = 0;
  logic srcValid = 0, dstReady = 0;
  logic [DATA_W-1:0] srcData = '0;
  logic srcReady, dstValid;
  logic [DATA_W-1:0] dstData;

  always #4    srcClk = ~srcClk;   // 125 MHz
  always #5.65 dstClk = ~dstClk;   // unrelated destination clock

  axiChanCdcFifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dut (.*);

  int checks = 0, errors = 0;
  int srcMode = 0, dstMode = 0;     // 0 idle, 1 always, 2 random
  int sendLimit = 0, popLimit = 0;
  int pushed = 0, popped = 0, srcCycles = 0;
  logic [DATA_W-1:0] model [$];
  bit pend = 0, prevReady = 1, holdPrev = 0;
  logic [DATA_W-1:0] heldData;

  function automatic logic [DATA_W-1:0] pattern(int n);
    return DATA_W'(n) * 32'h9E37_79B1 + 32'h0000_0005;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Source driver and reference push side.
  initial forever begin
    @(negedge srcClk);
    srcCycles++;
    if (!srcRstN) begin srcValid = 0; pend = 0; prevReady = 1; continue; end
    if (prevReady && !srcReady)
      check(pend, "R6", "srcReady fell without accepted beat", 0, 1);
    prevReady = srcReady;
    if (pend) srcValid = 0;
    if (!srcValid && pushed < sendLimit)
      srcValid = (srcMode == 1) || (srcMode == 2 && ($urandom % 3) != 0);
    srcData = pattern(pushed);
    pend = srcValid && srcReady;
    if (pend) begin
      model.push_back(srcData);
      pushed++;
      check(model.size() <= DEPTH, "R3", "accepted beyond capacity", model.size(), DEPTH);
    end
  end

  // Destination driver and scoreboard pop side.
  initial forever begin
    @(negedge dstClk);
    if (!dstRstN) begin dstReady = 0; holdPrev = 0; continue; end
    if (holdPrev)
      check(dstValid && dstData == heldData, "R5", "stalled beat changed", dstData, heldData);
    if (dstValid)
      check(model.size() > 0, "R2", "dstValid with nothing sent", 1, 0);
    dstReady = (popped < popLimit) &&
               ((dstMode == 1) || (dstMode == 2 && ($urandom % 2) == 0));
    if (dstValid && dstReady && model.size() > 0) begin
      check(dstData == model[0], "R4", "delivered beat", dstData, model[0]);
      void'(model.pop_front());
      popped++;
    end
    holdPrev = dstValid && !dstReady;
    heldData = dstData;
  end

  // Watchdog.
  initial begin
    wait (srcCycles > 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected<=%0d", srcCycles, 150000);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge srcClk);
    srcRstN = 1; dstRstN = 1;
    repeat (3) @(negedge srcClk);
    check(srcReady == 1, "R2", "srcReady after reset", srcReady, 1);
    @(negedge dstClk);
    check(dstValid == 0, "R2", "dstValid after reset", dstValid, 0);

    // Fill with destination stalled.
    sendLimit = 100; srcMode = 1; dstMode = 0; popLimit = 0;
    repeat (30) @(negedge srcClk);
    check(pushed == DEPTH, "R3", "beats accepted while stalled", pushed, DEPTH);
    check(srcReady == 0, "R1", "srcReady when full", srcReady, 0);
    check(srcValid == 1, "R3", "source still holding", srcValid, 1);
    repeat (10) @(negedge srcClk);
    check(srcReady == 0 && pushed == DEPTH, "R3", "held beat not taken", pushed, DEPTH);
    @(negedge dstClk);
    check(dstValid == 1, "R2", "dstValid with data", dstValid, 1);

    // Remove one beat and time the return of room.
    dstMode = 1; popLimit = 1;
    wait (popped == 1);
    begin
      int waited = 0;
      while (!srcReady && waited < 20) begin @(negedge srcClk); waited++; end
      check(waited <= 8, "R7", "cycles until room after pop", waited, 8);
    end
    repeat (4) @(negedge srcClk);
    check(pushed == DEPTH + 1, "R1", "one more beat accepted", pushed, DEPTH + 1);

    // Drain, then burst with always-ready destination.
    popLimit = 100;
    wait (popped == 100);
    check(pushed == 100 && model.size() == 0, "R4", "burst all delivered", pushed, 100);

    // Random stalls both sides.
    sendLimit = 3000; popLimit = 3000; srcMode = 2; dstMode = 2;
    wait (popped == 3000);
    repeat (20) @(negedge dstClk);
    check(pushed == 3000 && model.size() == 0, "R4", "random traffic lossless", popped, 3000);
    check(dstValid == 0, "R2", "dstValid low when drained", dstValid, 0);
    check(srcReady == 1, "R1", "srcReady high when drained", srcReady, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule